// File: doc/BRIEF.md
# Memory Pattern Fill-and-Verify Engine

This block tests a region of word-addressed memory on its own after a start pulse. It runs seven data-pattern tests one after another. Each test first writes every word of the current window and then reads the window back in ascending order, comparing each word with the value it wrote. The block drives a single-outstanding request/acknowledge master port that is 32 bits wide.

There are two coverage modes. Full mode treats the whole region as one window. Sampled mode takes only two 2 KiB windows from each whole mebibyte of the region: one at the start of that mebibyte and one ending at its last byte. The first mismatch ends the run and leaves the failing address, the expected word and the word that was read on the outputs. A one-cycle watchdog-kick pulse marks every 1024th word handled, so that a long fill does not starve a system watchdog.

Top module: `mem_pattern_tester`

## Requirements
- R1: For each window the tests run in this order: 0x00000000, 0xFFFFFFFF, 0x55555555, 0xAAAAAAAA, walking one, word index, inverted word index.
- R2: In the walking-one test the word at index i holds 1 << (i mod 32), so the pattern wraps every 32 words.
- R3: The word index used by the walking-one, index and inverted-index tests is the word offset from the start of the current window, not the absolute address.
- R4: Word i of a window is at byte address window_base + 4*i. Each test writes all words of the window in ascending order before it reads any of them, and it then reads them back in ascending order.
- R5: The first read whose data differs from the expected word ends the run. `error` rises and the address, expected word and read word of that access appear on `fail_addr`, `fail_expected` and `fail_read`. No further memory access follows. `error` holds until the next start.
- R6: `wdog_kick` is high for exactly the one cycle after each accepted transfer, in either phase, whose window word index is a multiple of 1024.
- R7: In sampled mode (`sampled_mode`=1), for each k below region_bytes >> 20, the full test sequence runs on 512 words at base + k*0x100000 and then on 512 words at base + k*0x100000 + 0xFF800. In full mode (`sampled_mode`=0) one window of region_bytes >> 2 words at the base is tested.
- R8: `sampled_mode`, `region_base` and `region_bytes` are captured only on the start pulse. Changing them during a run has no effect.
- R9: `done` is a one-cycle pulse that follows the last read of a passing run, the capture of a failure, or a start on a region that holds no window. In the last case no transfer is made and `error` stays low.
- R10: A transfer completes in a cycle where `mem_req` and `mem_ack` are both high. Until then `mem_addr`, `mem_we` and `mem_wdata` hold steady with `mem_req` high, and `mem_rdata` is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle start pulse, taken only when idle |
| sampled_mode | input | 1 | 1 selects sampled windows, 0 the whole region |
| region_base | input | 32 | Byte address of the region, word aligned |
| region_bytes | input | 32 | Region size in bytes |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge; completes the transfer |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on a read |
| done | output | 1 | Run finished pulse |
| error | output | 1 | A mismatch was found in the last run |
| fail_addr | output | 32 | Address of the failing read |
| fail_expected | output | 32 | Word that was expected there |
| fail_read | output | 32 | Word that was read there |
| wdog_kick | output | 1 | Watchdog service pulse |

## Verification
The checker assumes that the memory side keeps to the handshake. `mem_ack` only answers a pending request and is dropped for at least one cycle between transfers. The checker also assumes `start` arrives as a single-cycle pulse. The bench memory model acknowledges one cycle after it sees a request and always idles the cycle after an acknowledge, and `start` is raised for exactly one cycle per run. Faults are injected only in the read data returned by the model, so the write side and the handshake seen by the checker stay within these assumptions.

// File: rtl/mtest_pkg.sv
// Shared types for the memory pattern tester.
// Assumes the test order encoded in pat_sel_e is the order the tests run.
package mtest_pkg;

    localparam int NUM_TESTS = 7;

    typedef enum logic [2:0] {
        PAT_ZERO    = 3'd0,
        PAT_ONES    = 3'd1,
        PAT_ALT01   = 3'd2,
        PAT_ALT10   = 3'd3,
        PAT_WALK1   = 3'd4,
        PAT_INDEX   = 3'd5,
        PAT_INDEX_N = 3'd6
    } pat_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRITE,
        ST_READ,
        ST_ADVANCE
    } ctl_state_e;

endpackage

// File: rtl/mtest_pattern_gen.sv
// Combinational pattern source: gives the word that belongs at window
// word index idx for the selected test.
// Assumes DATA_W is even and a power of two (walking one wraps at DATA_W).
module mtest_pattern_gen
    import mtest_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 30
) (
    input  pat_sel_e           sel,
    input  logic [IDX_W-1:0]   idx,
    output logic [DATA_W-1:0]  word
);

    localparam int SH_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] idx_ext;

    // Fit the index to the data width (truncate or zero-extend).
    generate
        if (IDX_W >= DATA_W) begin : g_trunc
            assign idx_ext = idx[DATA_W-1:0];
        end else begin : g_ext
            assign idx_ext = {{(DATA_W-IDX_W){1'b0}}, idx};
        end
    endgenerate

    // Select the pattern word for the current test.
    always_comb begin
        case (sel)
            PAT_ZERO:    word = '0;
            PAT_ONES:    word = '1;
            PAT_ALT01:   word = {(DATA_W/2){2'b01}};
            PAT_ALT10:   word = {(DATA_W/2){2'b10}};
            PAT_WALK1:   word = ONE << idx[SH_W-1:0];
            PAT_INDEX:   word = idx_ext;
            PAT_INDEX_N: word = ~idx_ext;
            default:     word = '0;
        endcase
    end

endmodule

// File: rtl/mtest_window_seq.sv
// Window sequencer: captures the region on load and steps through the
// windows to test. In full mode there is one window covering the region;
// in sampled mode two WIN_BYTES windows per whole 2**MB_SHIFT block.
// Assumes step is raised only when last_win is low.
module mtest_window_seq #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 30,
    parameter int MB_SHIFT  = 20,
    parameter int WIN_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sampled_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] size_in,
    input  logic              step,
    output logic [ADDR_W-1:0] win_base,
    output logic [IDX_W-1:0]  win_words,
    output logic              last_win,
    output logic              empty
);

    localparam int MB_W = ADDR_W - MB_SHIFT;
    localparam logic [IDX_W-1:0]  WIN_WORDS = IDX_W'(WIN_BYTES / 4);
    localparam logic [ADDR_W-1:0] HI_OFF    = ADDR_W'((1 << MB_SHIFT) - WIN_BYTES);

    logic              sampled_q;
    logic [ADDR_W-1:0] base_q;
    logic [MB_W-1:0]   mb_count_q;
    logic [IDX_W-1:0]  full_words_q;
    logic [MB_W-1:0]   mb_q;
    logic              half_q;
    logic [ADDR_W-1:0] win_base_q;
    logic [MB_W-1:0]   mb_nxt;

    assign mb_nxt = mb_q + 1'b1;

    // Capture the region and walk the window list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sampled_q    <= 1'b0;
            base_q       <= '0;
            mb_count_q   <= '0;
            full_words_q <= '0;
            mb_q         <= '0;
            half_q       <= 1'b0;
            win_base_q   <= '0;
        end else if (load) begin
            sampled_q    <= sampled_in;
            base_q       <= base_in;
            mb_count_q   <= size_in[ADDR_W-1:MB_SHIFT];
            full_words_q <= size_in[ADDR_W-1:2];
            mb_q         <= '0;
            half_q       <= 1'b0;
            win_base_q   <= base_in;
        end else if (step && sampled_q) begin
            if (!half_q) begin
                half_q     <= 1'b1;
                win_base_q <= base_q + (ADDR_W'(mb_q) << MB_SHIFT) + HI_OFF;
            end else begin
                half_q     <= 1'b0;
                mb_q       <= mb_nxt;
                win_base_q <= base_q + (ADDR_W'(mb_nxt) << MB_SHIFT);
            end
        end
    end

    assign win_base  = win_base_q;
    assign win_words = sampled_q ? WIN_WORDS : full_words_q;
    assign last_win  = !sampled_q || (half_q && (mb_nxt == mb_count_q));
    assign empty     = sampled_q ? (mb_count_q == '0) : (full_words_q == '0);

endmodule

// File: rtl/mem_pattern_tester.sv
// Memory pattern fill-and-verify engine (top).
// For each window it runs seven tests; each writes the window, then reads
// it back and compares. The run stops at the first mismatch. One request is
// outstanding at a time; a transfer completes on mem_req && mem_ack.
// Assumes region_base is word aligned and start is a single-cycle pulse.
module mem_pattern_tester
    import mtest_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int MB_SHIFT   = 20,
    parameter int WIN_BYTES  = 2048,
    parameter int KICK_EVERY = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sampled_mode,
    input  logic [ADDR_W-1:0] region_base,
    input  logic [ADDR_W-1:0] region_bytes,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_expected,
    output logic [DATA_W-1:0] fail_read,
    output logic              wdog_kick
);

    localparam int IDX_W     = ADDR_W - 2;
    localparam int KICK_LOG2 = $clog2(KICK_EVERY);
    localparam logic [2:0] LAST_TEST = 3'(NUM_TESTS - 1);

    ctl_state_e        state;
    logic [2:0]        test_q;
    logic [IDX_W-1:0]  word_q;
    logic              done_q;
    logic              error_q;
    logic              kick_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic [DATA_W-1:0] fail_exp_q;
    logic [DATA_W-1:0] fail_got_q;

    logic [ADDR_W-1:0] win_base;
    logic [IDX_W-1:0]  win_words;
    logic              win_last;
    logic              win_empty;
    logic              win_load;
    logic              win_step;
    logic [DATA_W-1:0] exp_word;
    logic              last_word;
    logic              kick_hit;
    logic              mismatch;

    assign win_load  = (state == ST_IDLE) && start;
    assign win_step  = (state == ST_ADVANCE) && (test_q == LAST_TEST) && !win_last;
    assign last_word = (word_q == win_words - 1'b1);
    assign kick_hit  = (word_q[KICK_LOG2-1:0] == '0);
    assign mismatch  = (mem_rdata != exp_word);

    mtest_window_seq #(
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .MB_SHIFT  (MB_SHIFT),
        .WIN_BYTES (WIN_BYTES)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (win_load),
        .sampled_in (sampled_mode),
        .base_in    (region_base),
        .size_in    (region_bytes),
        .step       (win_step),
        .win_base   (win_base),
        .win_words  (win_words),
        .last_win   (win_last),
        .empty      (win_empty)
    );

    mtest_pattern_gen #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_pat (
        .sel  (pat_sel_e'(test_q)),
        .idx  (word_q),
        .word (exp_word)
    );

    // Control: sequence windows, tests and phases; capture the first failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            test_q      <= '0;
            word_q      <= '0;
            done_q      <= 1'b0;
            error_q     <= 1'b0;
            kick_q      <= 1'b0;
            fail_addr_q <= '0;
            fail_exp_q  <= '0;
            fail_got_q  <= '0;
        end else begin
            done_q <= 1'b0;
            kick_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_CHECK;
                        error_q <= 1'b0;
                        test_q  <= '0;
                        word_q  <= '0;
                    end
                end
                ST_CHECK: begin
                    if (win_empty) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        kick_q <= kick_hit;
                        if (last_word) begin
                            word_q <= '0;
                            state  <= ST_READ;
                        end else begin
                            word_q <= word_q + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        kick_q <= kick_hit;
                        if (mismatch) begin
                            error_q     <= 1'b1;
                            fail_addr_q <= mem_addr;
                            fail_exp_q  <= exp_word;
                            fail_got_q  <= mem_rdata;
                            done_q      <= 1'b1;
                            state       <= ST_IDLE;
                        end else if (last_word) begin
                            word_q <= '0;
                            state  <= ST_ADVANCE;
                        end else begin
                            word_q <= word_q + 1'b1;
                        end
                    end
                end
                ST_ADVANCE: begin
                    if (test_q == LAST_TEST) begin
                        test_q <= '0;
                        if (win_last) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_WRITE;
                        end
                    end else begin
                        test_q <= test_q + 1'b1;
                        state  <= ST_WRITE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req       = (state == ST_WRITE) || (state == ST_READ);
    assign mem_we        = (state == ST_WRITE);
    assign mem_addr      = win_base + {word_q, 2'b00};
    assign mem_wdata     = exp_word;
    assign done          = done_q;
    assign error         = error_q;
    assign fail_addr     = fail_addr_q;
    assign fail_expected = fail_exp_q;
    assign fail_read     = fail_got_q;
    assign wdog_kick     = kick_q;

endmodule

// File: rtl/mtest_checker.sv
// Protocol and timing checks for mem_pattern_tester, attached by bind.
// Assumes mem_ack only answers a pending request.
module mtest_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              done,
    input logic              error,
    input logic              wdog_kick
);

    // R10: a request waiting for acknowledge holds its fields.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R4: every access is word aligned.
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R6: a kick only follows an accepted transfer.
    a_r6_kick_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_kick |-> $past(mem_req && mem_ack));

    // R9: done lasts one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: no access is pending while done is shown.
    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R5: an error appears together with done.
    a_r5_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);

    // R5: no request follows the done of a failing run in the next cycle.
    a_r5_stop_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |=> !mem_req);

endmodule

bind mem_pattern_tester mtest_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_mtest_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .done      (done),
    .error     (error),
    .wdog_kick (wdog_kick)
);

// File: tb/tb_mem_pattern_tester.sv
// Scoreboard bench: a driver task queues the expected access stream,
// a monitor pops it on each accepted transfer and compares.
module tb_mem_pattern_tester;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sampled_mode = 1'b0;
    logic [31:0] region_base = '0;
    logic [31:0] region_bytes = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic        error;
    logic [31:0] fail_addr;
    logic [31:0] fail_expected;
    logic [31:0] fail_read;
    logic        wdog_kick;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mem_pattern_tester dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .sampled_mode  (sampled_mode),
        .region_base   (region_base),
        .region_bytes  (region_bytes),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .done          (done),
        .error         (error),
        .fail_addr     (fail_addr),
        .fail_expected (fail_expected),
        .fail_read     (fail_read),
        .wdog_kick     (wdog_kick)
    );

    // ---------------- memory model with fault injection ----------------
    logic [31:0] mem_model [logic [31:0]];
    int          fault_kind = 0;   // 0 none, 1 xor on read, 2 read aliases previous word
    logic [31:0] fault_addr = '0;
    logic [31:0] fault_mask = '0;

    function automatic logic [31:0] model_read(input logic [31:0] a);
        logic [31:0] src;
        logic [31:0] v;
        src = a;
        if (fault_kind == 2 && a == fault_addr) src = a - 32'd4;
        v = mem_model.exists(src) ? mem_model[src] : 32'h0;
        if (fault_kind == 1 && a == fault_addr) v = v ^ fault_mask;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem_model[mem_addr] = mem_wdata;
            else        mem_rdata <= model_read(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // ---------------- reporting ----------------
    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    bit          q_we[$];
    bit          q_kick[$];

    bit          stopped;
    bit          efail;
    logic [31:0] efail_addr, efail_exp, efail_got;
    int          kicks_exp, kicks_seen, xfers;

    function automatic logic [31:0] exp_pat(input int t, input int i);
        case (t)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h5555_5555;
            3: return 32'hAAAA_AAAA;
            4: return 32'h1 << (i % 32);
            5: return 32'(i);
            default: return ~32'(i);
        endcase
    endfunction

    task automatic push_window(input logic [31:0] wb, input int n);
        for (int t = 0; t < 7; t++) begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int i = 0; i < n; i++) begin
                    q_addr.push_back(wb + 32'(4 * i));
                    q_data.push_back(exp_pat(t, i));
                    q_we.push_back(ph == 0);
                    q_kick.push_back((i % 1024) == 0);
                end
            end
        end
    endtask

    task automatic build_expected(input bit smp, input logic [31:0] b, input logic [31:0] sz);
        q_addr.delete(); q_data.delete(); q_we.delete(); q_kick.delete();
        if (!smp) begin
            if ((sz >> 2) != 0) push_window(b, int'(sz >> 2));
        end else begin
            for (int k = 0; k < int'(sz >> 20); k++) begin
                push_window(b + (32'(k) << 20), 512);
                push_window(b + (32'(k) << 20) + 32'h000F_F800, 512);
            end
        end
    endtask

    // Monitor: compare each accepted transfer with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && wdog_kick) kicks_seen++;
        if (rst_n && mem_req && mem_ack) begin
            logic [31:0] ea, ed;
            bit ew, ek;
            xfers++;
            if (stopped) begin
                chk(1'b0, "R5", "transfer after mismatch", mem_addr, 32'h0);
            end else if (q_addr.size() == 0) begin
                chk(1'b0, "R4", "unexpected extra transfer", mem_addr, 32'h0);
            end else begin
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                ew = q_we.pop_front();
                ek = q_kick.pop_front();
                if (ek) kicks_exp++;
                chk(mem_addr == ea, "R4", "access address", mem_addr, ea);
                chk(mem_we == ew, "R4", "write/read phase", 32'(mem_we), 32'(ew));
                if (ew) begin
                    chk(mem_wdata == ed, "R1", "write data", mem_wdata, ed);
                end else if (mem_rdata != ed) begin
                    stopped    = 1'b1;
                    efail      = 1'b1;
                    efail_addr = ea;
                    efail_exp  = ed;
                    efail_got  = mem_rdata;
                end
            end
        end
    end

    // ---------------- run one case ----------------
    task automatic run_case(input string tag, input bit smp, input logic [31:0] b,
                            input logic [31:0] sz, input bit disturb);
        int wait_cnt;
        mem_model.delete();
        stopped = 0; efail = 0; kicks_exp = 0; kicks_seen = 0; xfers = 0;
        build_expected(smp, b, sz);
        @(negedge clk);
        sampled_mode = smp; region_base = b; region_bytes = sz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R8: inputs changed mid-run must not alter the run
            sampled_mode = ~smp; region_base = 32'h7000_0000; region_bytes = 32'h0;
        end
        wait_cnt = 0;
        while (!done && wait_cnt < 80000) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk(done == 1'b1, "R9", {tag, " done seen"}, 32'(done), 32'h1);
        chk(error == efail, "R5", {tag, " error flag"}, 32'(error), 32'(efail));
        if (efail) begin
            chk(fail_addr == efail_addr, "R5", {tag, " fail address"}, fail_addr, efail_addr);
            chk(fail_expected == efail_exp, "R5", {tag, " fail expected"}, fail_expected, efail_exp);
            chk(fail_read == efail_got, "R5", {tag, " fail read"}, fail_read, efail_got);
        end else begin
            chk(q_addr.size() == 0, "R7", {tag, " all expected transfers made"}, 32'(q_addr.size()), 32'h0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9", {tag, " done is one cycle"}, 32'(done), 32'h0);
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0, "R9", {tag, " idle after done"}, 32'(mem_req), 32'h0);
        chk(kicks_seen == kicks_exp, "R6", {tag, " kick count"}, 32'(kicks_seen), 32'(kicks_exp));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R9", "reset done", 32'(done), 32'h0);
        chk(error == 1'b0, "R5", "reset error", 32'(error), 32'h0);
        chk(mem_req == 1'b0, "R10", "reset request", 32'(mem_req), 32'h0);
        chk(wdog_kick == 1'b0, "R6", "reset kick", 32'(wdog_kick), 32'h0);

        // R1 R2 R3: 40 words, walking one wraps past 32, index from window start
        run_case("full40", 1'b0, 32'h0000_1000, 32'd160, 1'b0);

        // R6: 2050 words gives kicks at 0, 1024, 2048 in every phase
        run_case("full2050", 1'b0, 32'h0004_0000, 32'd8200, 1'b0);
        chk(kicks_exp == 42, "R6", "expected kick total", 32'(kicks_exp), 32'd42);

        // R5: bit flip on word 5 fails the first test
        fault_kind = 1; fault_addr = 32'h0000_1014; fault_mask = 32'h0000_0100;
        run_case("xorfault", 1'b0, 32'h0000_1000, 32'd64, 1'b0);
        chk(fail_addr == 32'h0000_1014 && fail_read == 32'h100, "R5", "flip fault report", fail_read, 32'h100);

        // R1 R2 R5: word 5 aliases word 4; constants pass, walking one fails
        fault_kind = 2; fault_addr = 32'h0000_3014;
        run_case("alias", 1'b0, 32'h0000_3000, 32'd64, 1'b0);
        chk(fail_expected == 32'h20 && fail_read == 32'h10, "R2", "alias caught by walking one",
            fail_read, 32'h10);

        // R5: clean run after a failure clears error
        fault_kind = 0;
        run_case("clean", 1'b0, 32'h0000_3000, 32'd64, 1'b0);

        // R7 R8: sampled mode over 1.5 MiB with inputs disturbed during the run
        run_case("sampled", 1'b1, 32'h2000_0000, 32'h0018_0000, 1'b1);

        // R7 R9: sampled region below one mebibyte, and empty full regions
        run_case("smp_small", 1'b1, 32'h2000_0000, 32'h0008_0000, 1'b0);
        chk(xfers == 0, "R9", "no transfers for small sampled region", 32'(xfers), 32'h0);
        run_case("full_zero", 1'b0, 32'h0000_1000, 32'd3, 1'b0);
        chk(xfers == 0, "R9", "no transfers for sub-word region", 32'(xfers), 32'h0);

        // R5 R7: fault in the second mebibyte's first window
        fault_kind = 1; fault_addr = 32'h1010_0008; fault_mask = 32'h1;
        run_case("smp_fault", 1'b1, 32'h1000_0000, 32'h0020_0000, 1'b0);
        chk(fail_addr == 32'h1010_0008, "R7", "sampled fault location", fail_addr, 32'h1010_0008);
        fault_kind = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule